// File: doc/BRIEF.md
# CEC Receive Byte Status and Acknowledge Handshake

This block is the byte-level receive side of a consumer-electronics-control bus controller. A bit-level line receiver hands it each completed block, made of a data byte and an end-of-message flag, or reports a line error for the block. The block stores each accepted byte in a receive buffer register and keeps a status register with four receive flags: byte ready, receive error, end of message and start of message. A host reads these flags, and writes zeros to clear them, through a simple register port.

Flow control is by refusal. If a new block completes while the host has not yet cleared the byte-ready flag of the previous byte, the block is refused. The line receiver is told not to acknowledge it on the bus, the receive buffer keeps the older byte, and the initiator then has to resend the whole message. The host can learn of a new byte by polling the status register, or through an interrupt that a configuration bit enables. Bit 0 of the status register shows, independently, a transmit-side arbitration-lost indication. It has no effect on receive behaviour.

Register map: address 0 is status, address 1 is the receive buffer (read only), and address 2 is configuration. Bit 0 of the configuration register is the interrupt enable. Reads are combinational from the current address. Other addresses read as zero.

Top module: `cec_rx_status`

## Requirements
- R1: After reset the status, receive buffer and configuration registers read 0x00, and both `irq` and `ack_ok` are low.
- R2: A block accepted as the first of a message sets byte-ready (status bit 7) and start-of-message (bit 4), so the status reads 0x90. The data byte then reads from the receive buffer.
- R3: A block accepted in the middle of a message, with end flag 0, sets only byte-ready, so the status reads 0x80.
- R4: A block accepted with end flag 1 sets byte-ready and end-of-message (bit 5), so the status reads 0xA0. The next accepted block is then marked as a start of message.
- R5: A host write to the status register clears each receive flag (bits 7..4) whose written bit is 0 and keeps each flag whose written bit is 1. Writing 0x00 returns the status to 0x00.
- R6: A block that completes while byte-ready is set is refused. `ack_ok` stays low, the receive buffer and the flags are unchanged, and the next accepted block is marked as a start of message.
- R7: A line error sets receive-error (bit 6) and never sets byte-ready. `ack_ok` stays low, and the next accepted block is marked as a start of message.
- R8: Status bit 0 mirrors `tx_arb_lost`, and the receive flags behave the same whatever its value.
- R9: `irq` is a register. It goes high one cycle after the interrupt enable (configuration bit 0) and either byte-ready or receive-error are both true, and it goes low one cycle after that condition ends.
- R10: `ack_ok` is high for exactly the one cycle after a `blk_valid` strobe whose block is accepted, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | One-cycle strobe: a block has completed and reached its acknowledge slot |
| blk_data | input | 8 | Data byte of the completed block |
| blk_eom | input | 1 | End-of-message flag of the completed block |
| line_err | input | 1 | One-cycle strobe: the current block had a line error |
| tx_arb_lost | input | 1 | Transmit arbitration-lost indication, shown at status bit 0 |
| ack_ok | output | 1 | Acknowledge decision for the line receiver, valid for one cycle |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
Each block or line-error strobe is captured at one rising edge. The flags, the receive buffer and `ack_ok` change at that same edge, and `irq` follows one edge later. A host write likewise takes effect at its single edge, and the matching change of `irq` comes one edge after it. The bench drives every input on the falling edge. It samples `ack_ok` and the registers on the falling edge right after the capturing edge, and waits one further falling edge before it looks at `irq`. Register reads are combinational, so they are sampled a short delay after the address is set, while no edge intervenes.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // Status bit positions; the host software decodes these.
    localparam int STAT_RDY_BIT  = 7;
    localparam int STAT_ERR_BIT  = 6;
    localparam int STAT_END_BIT  = 5;
    localparam int STAT_BEG_BIT  = 4;
    localparam int STAT_ARB_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_RXBUF  = 2'd1,
        ADDR_CONFIG = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic rdy;   // byte ready
        logic err;   // receive error
        logic fin;   // end of message
        logic beg;   // start of message
    } rx_flags_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              eom;
        logic              err;
    } rx_block_t;

    function automatic logic [DATA_W-1:0] pack_status(rx_flags_t f, logic arb);
        logic [DATA_W-1:0] s;
        s = '0;
        s[STAT_RDY_BIT] = f.rdy;
        s[STAT_ERR_BIT] = f.err;
        s[STAT_END_BIT] = f.fin;
        s[STAT_BEG_BIT] = f.beg;
        s[STAT_ARB_BIT] = arb;
        return s;
    endfunction

endpackage

// File: rtl/cec_rx_flags.sv
module cec_rx_flags
    import cec_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_block_t         blk,
    input  logic              wr_stat,
    input  logic [3:0]        keep_mask,
    output rx_flags_t         flags_q,
    output logic [DATA_W-1:0] rxbuf_q,
    output logic              ack_ok
);

    logic beg_pend_q;   // next accepted block opens a message
    logic accept;

    assign accept = blk.valid && !blk.err && !flags_q.rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            rxbuf_q    <= '0;
            ack_ok     <= 1'b0;
            beg_pend_q <= 1'b1;
        end else begin
            ack_ok <= accept;
            if (wr_stat) begin
                flags_q.rdy <= flags_q.rdy & keep_mask[3];
                flags_q.err <= flags_q.err & keep_mask[2];
                flags_q.fin <= flags_q.fin & keep_mask[1];
                flags_q.beg <= flags_q.beg & keep_mask[0];
            end
            if (blk.err) begin
                flags_q.err <= 1'b1;
                beg_pend_q  <= 1'b1;
            end else if (blk.valid) begin
                if (accept) begin
                    rxbuf_q     <= blk.data;
                    flags_q.rdy <= 1'b1;
                    flags_q.fin <= blk.eom;
                    flags_q.beg <= beg_pend_q;
                    beg_pend_q  <= blk.eom;
                end else begin
                    // refused: initiator will restart the whole message
                    beg_pend_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cec_rx_regs.sv
module cec_rx_regs
    import cec_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              ie_wdata,
    input  rx_flags_t         flags_q,
    input  logic [DATA_W-1:0] rxbuf_q,
    input  logic              tx_arb_lost,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wr_stat,
    output logic              ie_q
);

    assign wr_stat = reg_wr && (reg_addr == ADDR_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
        end else if (reg_wr && reg_addr == ADDR_CONFIG) begin
            ie_q <= ie_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata = pack_status(flags_q, tx_arb_lost);
            ADDR_RXBUF:  reg_rdata = rxbuf_q;
            ADDR_CONFIG: reg_rdata = {{(DATA_W-1){1'b0}}, ie_q};
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cec_rx_irq.sv
module cec_rx_irq
    import cec_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ie_q,
    input  rx_flags_t flags_q,
    output logic      irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ie_q && (flags_q.rdy || flags_q.err);
    end

endmodule

// File: rtl/cec_rx_status.sv
module cec_rx_status
    import cec_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_valid,
    input  logic [DATA_W-1:0] blk_data,
    input  logic              blk_eom,
    input  logic              line_err,
    input  logic              tx_arb_lost,
    output logic              ack_ok,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    rx_block_t         blk;
    rx_flags_t         flags_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic              wr_stat;
    logic              ie_q;

    assign blk = '{valid: blk_valid, data: blk_data, eom: blk_eom, err: line_err};

    cec_rx_flags i_flags (
        .clk       (clk),
        .rst       (rst),
        .blk       (blk),
        .wr_stat   (wr_stat),
        .keep_mask (reg_wdata[STAT_RDY_BIT:STAT_BEG_BIT]),
        .flags_q   (flags_q),
        .rxbuf_q   (rxbuf_q),
        .ack_ok    (ack_ok)
    );

    cec_rx_regs i_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .ie_wdata    (reg_wdata[0]),
        .flags_q     (flags_q),
        .rxbuf_q     (rxbuf_q),
        .tx_arb_lost (tx_arb_lost),
        .reg_rdata   (reg_rdata),
        .wr_stat     (wr_stat),
        .ie_q        (ie_q)
    );

    cec_rx_irq i_irq (
        .clk     (clk),
        .rst     (rst),
        .ie_q    (ie_q),
        .flags_q (flags_q),
        .irq     (irq)
    );

endmodule

// File: rtl/cec_rx_status_chk.sv
module cec_rx_status_chk
    import cec_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              blk_valid,
    input logic [DATA_W-1:0] blk_data,
    input logic              blk_eom,
    input logic              line_err,
    input logic              ack_ok,
    input logic              irq,
    input rx_flags_t         flags_q,
    input logic [DATA_W-1:0] rxbuf_q,
    input logic              ie_q
);

    // R2: an accepted block loads the buffer and raises byte-ready
    a_r2_accept_loads: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && !line_err && !flags_q.rdy) |=>
            (ack_ok && flags_q.rdy && rxbuf_q == $past(blk_data)));

    // R4: end flag of an accepted block reaches the status
    a_r4_end_flag: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && !line_err && !flags_q.rdy && blk_eom) |=> flags_q.fin);

    // R6: refused block leaves the buffer alone and is not acknowledged
    a_r6_refuse: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && flags_q.rdy) |=> (!ack_ok && $stable(rxbuf_q)));

    // R7: a line error raises receive-error without acknowledge
    a_r7_line_err: assert property (@(posedge clk) disable iff (rst)
        line_err |=> (flags_q.err && !ack_ok));

    // R9: an enabled pending flag raises the interrupt next cycle
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (ie_q && (flags_q.rdy || flags_q.err)) |=> irq);

    // R9: no interrupt without enable
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !ie_q |=> !irq);

    // R10: acknowledge only right after a block strobe
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_ok |-> ($past(blk_valid) && !$past(line_err)));

endmodule

bind cec_rx_status cec_rx_status_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_valid (blk_valid),
    .blk_data  (blk_data),
    .blk_eom   (blk_eom),
    .line_err  (line_err),
    .ack_ok    (ack_ok),
    .irq       (irq),
    .flags_q   (flags_q),
    .rxbuf_q   (rxbuf_q),
    .ie_q      (ie_q)
);

// File: tb/test_cec_rx_status.sv
`timescale 1ns/1ps
module test_cec_rx_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blk_valid = 1'b0;
    logic [7:0] blk_data = 8'h00;
    logic       blk_eom = 1'b0;
    logic       line_err = 1'b0;
    logic       tx_arb_lost = 1'b0;
    logic       ack_ok;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    cec_rx_status i_cec_rx_status (
        .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_data(blk_data),
        .blk_eom(blk_eom), .line_err(line_err), .tx_arb_lost(tx_arb_lost),
        .ack_ok(ack_ok), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // drives one block, returns ack_ok seen one edge later
    task automatic send(input logic [7:0] d, input logic eom, input logic err, output logic ack);
        @(negedge clk);
        blk_valid = 1'b1; blk_data = d; blk_eom = eom; line_err = err;
        @(negedge clk);
        ack = ack_ok;
        blk_valid = 1'b0; line_err = 1'b0; blk_eom = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 status", v, 8'h00);
        rd(2'd1, v); check("R1 rxbuf", v, 8'h00);
        rd(2'd2, v); check("R1 config", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 ack_ok", {7'd0, ack_ok}, 8'h00);
    endtask

    task automatic t_message();
        logic [7:0] v; logic a;
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R9 enable bit", v, 8'h01);
        send(8'h40, 1'b0, 1'b0, a);
        check("R10 ack header", {7'd0, a}, 8'h01);
        check("R9 irq lags flag", {7'd0, irq}, 8'h00);
        rd(2'd0, v); check("R2 header status", v, 8'h90);
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        rd(2'd1, v); check("R2 rxbuf", v, 8'h40);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R5 clear", v, 8'h00);
        check("R9 irq dropped", {7'd0, irq}, 8'h00);
        send(8'h36, 1'b0, 1'b0, a);
        rd(2'd0, v); check("R3 middle status", v, 8'h80);
        wr(2'd0, 8'h00);
        send(8'h5A, 1'b1, 1'b0, a);
        rd(2'd0, v); check("R4 last status", v, 8'hA0);
        rd(2'd1, v); check("R4 last rxbuf", v, 8'h5A);
        wr(2'd0, 8'h00);
        send(8'h0F, 1'b0, 1'b0, a);
        rd(2'd0, v); check("R4 new message start", v, 8'h90);
    endtask

    task automatic t_refuse();
        logic [7:0] v; logic a;
        send(8'h55, 1'b0, 1'b0, a);
        check("R6 ack refused", {7'd0, a}, 8'h00);
        rd(2'd1, v); check("R6 rxbuf kept", v, 8'h0F);
        rd(2'd0, v); check("R6 flags kept", v, 8'h90);
        @(negedge clk);
        check("R10 ack idle", {7'd0, ack_ok}, 8'h00);
        wr(2'd0, 8'h10);
        rd(2'd0, v); check("R5 partial clear", v, 8'h10);
        wr(2'd0, 8'h00);
        send(8'h77, 1'b0, 1'b0, a);
        rd(2'd0, v); check("R6 restart marked start", v, 8'h90);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_error();
        logic [7:0] v; logic a;
        send(8'h11, 1'b0, 1'b0, a);
        rd(2'd0, v); check("R3 before error", v, 8'h80);
        wr(2'd0, 8'h00);
        send(8'h22, 1'b0, 1'b1, a);
        check("R7 no ack on error", {7'd0, a}, 8'h00);
        rd(2'd0, v); check("R7 error status", v, 8'h40);
        check("R9 irq on error", {7'd0, irq}, 8'h01);
        rd(2'd1, v); check("R7 rxbuf kept", v, 8'h11);
        wr(2'd0, 8'h00);
        send(8'h33, 1'b0, 1'b0, a);
        rd(2'd0, v); check("R7 next is start", v, 8'h90);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_arb();
        logic [7:0] v; logic a;
        tx_arb_lost = 1'b1;
        rd(2'd0, v); check("R8 arb bit", v, 8'h01);
        send(8'h44, 1'b0, 1'b0, a);
        check("R8 ack with arb", {7'd0, a}, 8'h01);
        rd(2'd0, v); check("R8 middle with arb", v, 8'h81);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R8 cleared with arb", v, 8'h01);
        tx_arb_lost = 1'b0;
    endtask

    task automatic t_irq_off();
        logic [7:0] v; logic a;
        wr(2'd2, 8'h00);
        send(8'h66, 1'b1, 1'b0, a);
        rd(2'd0, v); check("R4 end while masked", v, 8'hA0);
        @(negedge clk);
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_message();
        t_refuse();
        t_error();
        t_arb();
        t_irq_off();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule